// File: doc/BRIEF.md
# Four-bit function-select ALU slice

A purely combinational arithmetic/logic slice working on two operand words. A four-bit select word and a mode input pick one of sixteen bitwise logic functions or one of sixteen two's-complement arithmetic functions. The carry input is inverted: high means "no carry", and low adds one to any arithmetic result. Only the active-high data convention is modelled.

Every function comes from one pair of bitwise terms built from A, B and the select word. Each arithmetic result is the sum of those two terms plus the carry. Each logic result is the complemented exclusive-OR of the same two terms, with no carry involved.

A slice offers three ways to build wider words. An active-low ripple carry output chains slices directly. Active-low group propagate and group generate outputs feed an external look-ahead unit. An all-ones flag on the result, combined with the carry output in the subtract code, compares the two operands.

Top module: `logic_arith_slice`

## Requirements
- R1: With `logic_mode_i`=1, `f_o` is, for `sel_i` 0 to 15: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A.
- R2: With `logic_mode_i`=1, `carry_in_n_i` has no effect on `f_o`.
- R3: With `logic_mode_i`=0 and `carry_in_n_i`=1, `f_o` is, for `sel_i` 0 to 15, modulo 2^WIDTH: A, A|B, A|~B, -1, A+(A&~B), (A|B)+(A&~B), A-B-1, (A&~B)-1, A+(A&B), A+B, (A|~B)+(A&B), (A&B)-1, A+A, (A|B)+A, (A|~B)+A, A-1.
- R4: With `logic_mode_i`=0 and `carry_in_n_i`=0, `f_o` is the R3 value plus one, modulo 2^WIDTH.
- R5: The operand pair is X = A|(B&S0)|(~B&S1) and Y = (A&B&S3)|(A&~B&S2), bitwise, where Sk is `sel_i[k]` copied across the width. `carry_out_n_o` is 0 exactly when X+Y+(~`carry_in_n_i`) exceeds 2^WIDTH-1. This holds in both modes.
- R6: `gen_n_o` is 0 exactly when X+Y exceeds 2^WIDTH-1. `prop_n_o` is 0 exactly when X is all ones. Neither output depends on mode or carry input.
- R7: `eq_o` is 1 exactly when every bit of `f_o` is 1.
- R8: With `logic_mode_i`=0, `sel_i`=4'b0110 and `carry_in_n_i`=1, `eq_o` is 1 exactly when A equals B.
- R9: With `logic_mode_i`=0 and `sel_i`=4'b0110, unsigned magnitude is given by two pairs. With `carry_in_n_i`=1, `carry_out_n_o`=1 means A<=B and 0 means A>B. With `carry_in_n_i`=0, `carry_out_n_o`=1 means A<B and 0 means A>=B.
- R10: Slices chained by ripple, each `carry_out_n_o` driving the next `carry_in_n_i`, give the R1, R3 and R4 results and the R5 carry out for the full combined width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | 1 = logic functions, 0 = arithmetic |
| carry_in_n_i | input | 1 | Carry input, low = carry asserted |
| f_o | output | WIDTH | Function result |
| carry_out_n_o | output | 1 | Ripple carry output, low = carry out |
| prop_n_o | output | 1 | Group propagate, active low |
| gen_n_o | output | 1 | Group generate, active low |
| eq_o | output | 1 | High when the result is all ones |

## Verification
The bench builds the slice at its default WIDTH of 4. At that width every combination of operands, select code, mode and carry input can be swept, which is 16,384 cases, so every function and every carry boundary is reached. A second set of four WIDTH=4 slices, chained by ripple, forms a 16-bit word. It runs every code in both modes with both carry values over edge and pseudo-random operands, which exercises carries crossing slice boundaries.

// File: rtl/logic_arith_slice.sv
module logic_arith_slice #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             logic_mode_i,
  input  logic             carry_in_n_i,
  output logic [WIDTH-1:0] f_o,
  output logic             carry_out_n_o,
  output logic             prop_n_o,
  output logic             gen_n_o,
  output logic             eq_o
);

  logic [WIDTH-1:0] or_term;
  logic [WIDTH-1:0] and_term;
  logic [WIDTH:0]   carry;
  logic             grp_gen;

  assign or_term  = a_i | (b_i & {WIDTH{sel_i[0]}}) | (~b_i & {WIDTH{sel_i[1]}});
  assign and_term = (a_i & b_i & {WIDTH{sel_i[3]}}) | (a_i & ~b_i & {WIDTH{sel_i[2]}});

  assign carry[0] = ~carry_in_n_i;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign carry[i+1] = and_term[i] | (or_term[i] & carry[i]);
    end
  endgenerate

  always_comb begin
    grp_gen = 1'b0;
    for (int k = 0; k < WIDTH; k++) begin
      grp_gen = and_term[k] | (or_term[k] & grp_gen);
    end
  end

  assign f_o           = logic_mode_i ? ~(or_term ^ and_term)
                                      : (or_term ^ and_term ^ carry[WIDTH-1:0]);
  assign carry_out_n_o = ~carry[WIDTH];
  assign prop_n_o      = ~(&or_term);
  assign gen_n_o       = ~grp_gen;
  assign eq_o          = &f_o;

endmodule

module logic_arith_slice_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       sel_i,
  input logic             logic_mode_i,
  input logic             carry_in_n_i,
  input logic [WIDTH-1:0] f_o,
  input logic             carry_out_n_o,
  input logic             prop_n_o,
  input logic             gen_n_o,
  input logic             eq_o
);

  logic             known;
  logic             sub_code;
  logic [WIDTH-1:0] plain_sum;

  assign known     = !$isunknown({a_i, b_i, sel_i, logic_mode_i, carry_in_n_i,
                                  f_o, carry_out_n_o, prop_n_o, gen_n_o, eq_o});
  assign sub_code  = !logic_mode_i && (sel_i == 4'b0110);
  assign plain_sum = a_i + b_i + {{(WIDTH-1){1'b0}}, ~carry_in_n_i};

  always_comb begin
    if (known) begin
      if (logic_mode_i && sel_i == 4'b1111)
        assert_logic_pass_a_R1: assert (f_o == a_i);
      if (logic_mode_i && sel_i == 4'b1100)
        assert_logic_all_ones_R1: assert (eq_o);
      if (!logic_mode_i && sel_i == 4'b1001)
        assert_add_code_R4: assert (f_o == plain_sum);
      assert_carry_vs_group_R5: assert (carry_out_n_o == (gen_n_o & (prop_n_o | carry_in_n_i)));
      if (!gen_n_o)
        assert_gen_implies_prop_R6: assert (!carry_out_n_o);
      if (sub_code && carry_in_n_i)
        assert_sub_equal_R8: assert (eq_o == (a_i == b_i));
      if (sub_code && carry_in_n_i)
        assert_mag_greater_R9: assert ((!carry_out_n_o) == (a_i > b_i));
      if (sub_code && !carry_in_n_i)
        assert_mag_less_R9: assert (carry_out_n_o == (a_i < b_i));
    end
  end

endmodule

bind logic_arith_slice logic_arith_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .sel_i(sel_i), .logic_mode_i(logic_mode_i),
  .carry_in_n_i(carry_in_n_i), .f_o(f_o), .carry_out_n_o(carry_out_n_o),
  .prop_n_o(prop_n_o), .gen_n_o(gen_n_o), .eq_o(eq_o)
);

// File: tb/logic_arith_slice_tb.sv
module logic_arith_slice_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [3:0] a, b, sel;
  logic       mode, cin_n;
  logic [3:0] f;
  logic       cout_n, p_n, g_n, eq;

  logic_arith_slice #(.WIDTH(4)) u_dut (
    .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(mode), .carry_in_n_i(cin_n),
    .f_o(f), .carry_out_n_o(cout_n), .prop_n_o(p_n), .gen_n_o(g_n), .eq_o(eq)
  );

  logic [15:0] wa, wb, wf;
  logic [3:0]  wsel;
  logic        wmode;
  logic [4:0]  chain_n;
  logic [3:0]  wp_n, wg_n, weq;

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_chain
      logic_arith_slice #(.WIDTH(4)) u_s (
        .a_i(wa[4*gi +: 4]), .b_i(wb[4*gi +: 4]), .sel_i(wsel), .logic_mode_i(wmode),
        .carry_in_n_i(chain_n[gi]), .f_o(wf[4*gi +: 4]), .carry_out_n_o(chain_n[gi+1]),
        .prop_n_o(wp_n[gi]), .gen_n_o(wg_n[gi]), .eq_o(weq[gi])
      );
    end
  endgenerate

  function automatic logic [15:0] logic_ref(input logic [3:0] c, input logic [15:0] x,
                                            input logic [15:0] y, input logic [15:0] m);
    logic [15:0] r;
    case (c)
      4'd0:  r = ~x;
      4'd1:  r = ~(x | y);
      4'd2:  r = ~x & y;
      4'd3:  r = 16'h0;
      4'd4:  r = ~(x & y);
      4'd5:  r = ~y;
      4'd6:  r = x ^ y;
      4'd7:  r = x & ~y;
      4'd8:  r = ~x | y;
      4'd9:  r = ~(x ^ y);
      4'd10: r = y;
      4'd11: r = x & y;
      4'd12: r = 16'hFFFF;
      4'd13: r = x | ~y;
      4'd14: r = x | y;
      default: r = x;
    endcase
    return r & m;
  endfunction

  function automatic logic [15:0] arith_ref(input logic [3:0] c, input logic [15:0] x,
                                            input logic [15:0] y, input logic [15:0] m);
    logic [15:0] ny, r;
    ny = ~y & m;
    case (c)
      4'd0:  r = x;
      4'd1:  r = x | y;
      4'd2:  r = x | ny;
      4'd3:  r = 16'hFFFF;
      4'd4:  r = x + (x & ny);
      4'd5:  r = (x | y) + (x & ny);
      4'd6:  r = x - y - 16'd1;
      4'd7:  r = (x & ny) - 16'd1;
      4'd8:  r = x + (x & y);
      4'd9:  r = x + y;
      4'd10: r = (x | ny) + (x & y);
      4'd11: r = (x & y) - 16'd1;
      4'd12: r = x + x;
      4'd13: r = (x | y) + x;
      4'd14: r = (x | ny) + x;
      default: r = x - 16'd1;
    endcase
    return r & m;
  endfunction

  function automatic logic [16:0] pair_sum(input logic [3:0] c, input logic [15:0] x,
                                           input logic [15:0] y, input logic [15:0] m,
                                           input logic cy);
    logic [15:0] t1, t2;
    t1 = (x | (y & {16{c[0]}}) | (~y & {16{c[1]}})) & m;
    t2 = ((x & y & {16{c[3]}}) | (x & ~y & {16{c[2]}})) & m;
    return {1'b0, t1} + {1'b0, t2} + {16'd0, cy};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h (sel=%b mode=%b cin_n=%b a=%h b=%h)",
               req, act, exp, sel, mode, cin_n, a, b);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    a = 4'h0; b = 4'h0; sel = 4'h0; mode = 1'b0; cin_n = 1'b1;
    wa = 16'h0; wb = 16'h0; wsel = 4'h0; wmode = 1'b0; chain_n[0] = 1'b1;
    @(negedge clk);
    check("R3 idle result", {12'd0, f}, 16'h0000);
    check("R5 idle carry", {15'd0, cout_n}, 16'h0001);
    check("R6 idle prop", {15'd0, p_n}, 16'h0001);
    check("R6 idle gen", {15'd0, g_n}, 16'h0001);
    check("R7 idle eq", {15'd0, eq}, 16'h0000);

    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
              logic [15:0] ef;
              logic [16:0] s_c, s_0;
              @(posedge clk);
              mode = m[0]; sel = 4'(c); cin_n = ci[0]; a = 4'(ia); b = 4'(ib);
              @(negedge clk);
              if (mode) ef = logic_ref(sel, {12'd0, a}, {12'd0, b}, 16'h000F);
              else ef = (arith_ref(sel, {12'd0, a}, {12'd0, b}, 16'h000F)
                         + {15'd0, ~cin_n}) & 16'h000F;
              if (mode && !cin_n) check("R2 logic ignores carry", {12'd0, f}, ef);
              else if (mode)      check("R1 logic function", {12'd0, f}, ef);
              else if (cin_n)     check("R3 arithmetic no carry", {12'd0, f}, ef);
              else                check("R4 arithmetic plus carry", {12'd0, f}, ef);
              s_c = pair_sum(sel, {12'd0, a}, {12'd0, b}, 16'h000F, ~cin_n);
              s_0 = pair_sum(sel, {12'd0, a}, {12'd0, b}, 16'h000F, 1'b0);
              check("R5 ripple carry out", {15'd0, cout_n}, {15'd0, !(s_c > 17'd15)});
              check("R6 group generate", {15'd0, g_n}, {15'd0, !(s_0 > 17'd15)});
              check("R6 group propagate", {15'd0, p_n},
                    {15'd0, !(((a | (b & {4{sel[0]}}) | (~b & {4{sel[1]}}))) == 4'hF)});
              check("R7 all-ones flag", {15'd0, eq}, {15'd0, ef[3:0] == 4'hF});
              if (!mode && sel == 4'b0110) begin
                if (cin_n) begin
                  check("R8 equality", {15'd0, eq}, {15'd0, a == b});
                  check("R9 magnitude a<=b", {15'd0, cout_n}, {15'd0, a <= b});
                end else begin
                  check("R9 magnitude a<b", {15'd0, cout_n}, {15'd0, a < b});
                end
              end
            end
          end
        end
      end
    end

    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int k = 0; k < 24; k++) begin
            logic [15:0] ef;
            logic [16:0] s_c;
            @(posedge clk);
            wmode = m[0]; wsel = 4'(c); chain_n[0] = ci[0];
            case (k)
              0: begin wa = 16'h0000; wb = 16'h0000; end
              1: begin wa = 16'hFFFF; wb = 16'h0001; end
              2: begin wa = 16'h8000; wb = 16'h8000; end
              3: begin wa = 16'h00FF; wb = 16'hFF00; end
              default: begin
                wa = 16'(k * 40503 + 17);
                wb = k[0] ? wa : 16'(k * 9973 + 5);
              end
            endcase
            @(negedge clk);
            if (wmode) ef = logic_ref(wsel, wa, wb, 16'hFFFF);
            else ef = arith_ref(wsel, wa, wb, 16'hFFFF) + {15'd0, ~chain_n[0]};
            check("R10 chained result", wf, ef);
            s_c = pair_sum(wsel, wa, wb, 16'hFFFF, ~chain_n[0]);
            check("R10 chained carry out", {15'd0, chain_n[4]}, {15'd0, !(s_c > 17'hFFFF)});
          end
        end
      end
    end

    finish_run();
  end

endmodule